// File: doc/BRIEF.md
# MSI Doorbell Interrupt Controller

This block watches a stream of inbound memory writes and picks out the ones that are message-signalled interrupts. A write counts as an interrupt when three things hold: delivery is enabled, the write address equals a programmed 64-bit doorbell address, and the low half of the write data agrees with a programmed match value on every bit that a programmed mask selects. The data bits the mask leaves open give a vector number. That vector sets one bit in a pending register.

Every other inbound write leaves on a forward port one cycle later, with its address and data unchanged. A small register port lets software read the pending bits, force them, clear them, mask and unmask sources, program the doorbell address and the match word, and read a hardware revision. The block drives one level-sensitive interrupt line, which is high while any unmasked pending bit is set.

A parameter holds the hardware revision, and the revision selects the layout of the pending bits. From revision 0x0303 on, there are 32 vectors starting at pending bit 0. Below that revision, there are 8 vectors in the top byte of the pending register, and the lower 24 bits are kept for other interrupt sources.

Top module: `msi_doorbell_ctrl`

## Requirements
- R1: After reset, the pending bits are 0, every vector mask bit is 1, delivery is disabled, the interrupt line is low, and the doorbell address and match registers read 0.
- R2: An inbound write is recognised only when all three of these hold: the enable bit (bit 0 of the address-low register) is 1; in_addr[63:2] equals {address-high, address-low[31:2]}, with in_addr[1:0] ignored; and ((in_data[15:0] XOR match) AND mask) is zero, where match is config[15:0] and mask is config[31:16].
- R3: The vector of a recognised write is in_data[15:0] AND NOT mask. The write sets pending bit (base + vector) on the clock edge that samples it. When the vector is not below the vector count, the write is consumed and sets nothing.
- R4: If HW_REV is 0x0303 or higher, there are 32 vectors at base 0. Otherwise there are 8 vectors at base 24. Pending and mask bits outside the vector range always read 0, and writes to them are ignored.
- R5: The register map, as a word index on reg_addr, is: 0 pending (read), 1 set (write 1 to set), 2 clear (write 1 to clear), 3 mask (read), 4 mask-set (write 1 to mask), 5 mask-clear (write 1 to unmask), 6 address-low (bit 0 is enable, bit 1 reads 0), 7 address-high, 8 config, 9 revision. All other indices, and indices 1, 2, 4 and 5, read 0. Writes to indices 0, 3 and 9 are ignored. Reads are combinational.
- R6: In the set, clear, mask-set and mask-clear registers, only the 1 bits act. The 0 bits leave the state as it is.
- R7: A recognised write that arrives in the same cycle as a clear of its own pending bit leaves that bit set.
- R8: irq is high exactly when (pending AND NOT mask) is non-zero, and it follows that state after the same clock edge.
- R9: An inbound write that is not recognised appears on fwd_valid/fwd_addr/fwd_data one cycle later, unchanged. A recognised write is never forwarded. Writes that are not recognised do not change the pending bits.
- R10: Revision register bits 15:0 read HW_REV, and bits 31:16 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Inbound write strobe |
| in_addr | input | ADDR_W | Inbound write address |
| in_data | input | DATA_W | Inbound write data |
| fwd_valid | output | 1 | Forwarded write strobe |
| fwd_addr | output | ADDR_W | Forwarded write address |
| fwd_data | output | DATA_W | Forwarded write data |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word index |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data (combinational) |
| irq | output | 1 | Level interrupt toward the CPU |

## Verification
The block has two timings. Pending bits, mask bits, the configuration, the forward port and irq all change on the rising edge that samples the inbound write or the register write. reg_rdata follows reg_addr in the same cycle. The bench drives its inputs on the falling edge. At each rising edge it advances a behavioural model of both a current-revision instance and a legacy-revision instance, and it compares irq, the forward port and reg_rdata 1 ns later, so every result is read in the first cycle it is due. Hand-computed register reads after each stimulus group pin down the expected pending and mask words for the vector decode, the address and data match, the layout and the clear collision.

// File: rtl/msi_db_pkg.sv
`timescale 1ns/1ps
package msi_db_pkg;
  localparam int REG_AW = 4;
  localparam logic [15:0] REV_WIDE_LAYOUT = 16'h0303;

  typedef enum logic [REG_AW-1:0] {
    RA_PEND     = 4'd0,
    RA_SET      = 4'd1,
    RA_CLEAR    = 4'd2,
    RA_MASK     = 4'd3,
    RA_MASK_SET = 4'd4,
    RA_MASK_CLR = 4'd5,
    RA_TGT_LO   = 4'd6,
    RA_TGT_HI   = 4'd7,
    RA_DCFG     = 4'd8,
    RA_REV      = 4'd9
  } reg_idx_e;
endpackage

// File: rtl/msi_db_cfg.sv
`timescale 1ns/1ps
module msi_db_cfg import msi_db_pkg::*; #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] tgt_lo_q,
  output logic [DATA_W-1:0] tgt_hi_q,
  output logic [DATA_W-1:0] dcfg_q
);
  logic              lo_en, hi_en, cfg_en;
  logic [DATA_W-1:0] tgt_lo_d;

  always_comb begin
    lo_en  = reg_we && (reg_addr == RA_TGT_LO);
    hi_en  = reg_we && (reg_addr == RA_TGT_HI);
    cfg_en = reg_we && (reg_addr == RA_DCFG);
    tgt_lo_d    = reg_wdata;
    tgt_lo_d[1] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tgt_lo_q <= '0;
      tgt_hi_q <= '0;
      dcfg_q   <= '0;
    end else begin
      if (lo_en)  tgt_lo_q <= tgt_lo_d;
      if (hi_en)  tgt_hi_q <= reg_wdata;
      if (cfg_en) dcfg_q   <= reg_wdata;
    end
  end
endmodule

// File: rtl/msi_db_match.sv
`timescale 1ns/1ps
module msi_db_match #(
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 64,
  parameter int STAT_W   = 32,
  parameter int NUM_VEC  = 32,
  parameter int VEC_BASE = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [DATA_W-1:0] in_data,
  input  logic              msi_en,
  input  logic [ADDR_W-1:0] tgt_addr,
  input  logic [DATA_W/2-1:0] match_mask,
  input  logic [DATA_W/2-1:0] match_val,
  output logic              recog,
  output logic [STAT_W-1:0] hit_vec,
  output logic              fwd_valid,
  output logic [ADDR_W-1:0] fwd_addr,
  output logic [DATA_W-1:0] fwd_data
);
  localparam int FW = DATA_W / 2;

  logic          addr_ok, data_ok;
  logic [FW-1:0] vec_free;
  logic          fwd_valid_d;
  logic          unused_bits;

  assign unused_bits = ^{in_data[DATA_W-1:FW], tgt_addr[1:0]};

  always_comb begin
    addr_ok  = (in_addr[ADDR_W-1:2] == tgt_addr[ADDR_W-1:2]);
    data_ok  = (((in_data[FW-1:0] ^ match_val) & match_mask) == '0);
    recog    = in_valid && msi_en && addr_ok && data_ok;
    vec_free = in_data[FW-1:0] & ~match_mask;
    hit_vec  = '0;
    for (int i = 0; i < NUM_VEC; i++) begin
      if (recog && (vec_free == FW'(i))) hit_vec[VEC_BASE+i] = 1'b1;
    end
    fwd_valid_d = in_valid && !recog;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fwd_valid <= 1'b0;
      fwd_addr  <= '0;
      fwd_data  <= '0;
    end else begin
      fwd_valid <= fwd_valid_d;
      if (fwd_valid_d) begin
        fwd_addr <= in_addr;
        fwd_data <= in_data;
      end
    end
  end
endmodule

// File: rtl/msi_db_pending.sv
`timescale 1ns/1ps
module msi_db_pending #(
  parameter int STAT_W   = 32,
  parameter int NUM_VEC  = 32,
  parameter int VEC_BASE = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_wr,
  input  logic              clr_wr,
  input  logic              mset_wr,
  input  logic              mclr_wr,
  input  logic [STAT_W-1:0] wdata,
  input  logic [STAT_W-1:0] msi_set,
  output logic [STAT_W-1:0] status,
  output logic [STAT_W-1:0] mask,
  output logic              irq
);
  for (genvar g = 0; g < STAT_W; g++) begin : g_bit
    if ((g >= VEC_BASE) && (g < VEC_BASE + NUM_VEC)) begin : g_vec
      logic st_q, st_d, st_en;
      logic mk_q, mk_d, mk_en;

      always_comb begin
        st_en = (clr_wr && wdata[g]) || (set_wr && wdata[g]) || msi_set[g];
        st_d  = msi_set[g] || (set_wr && wdata[g]);
        mk_en = (mset_wr || mclr_wr) && wdata[g];
        mk_d  = mset_wr;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          st_q <= 1'b0;
          mk_q <= 1'b1;
        end else begin
          if (st_en) st_q <= st_d;
          if (mk_en) mk_q <= mk_d;
        end
      end

      assign status[g] = st_q;
      assign mask[g]   = mk_q;
    end else begin : g_rsv
      logic unused_lane;
      assign unused_lane = wdata[g] ^ msi_set[g];
      assign status[g]   = 1'b0;
      assign mask[g]     = 1'b0;
    end
  end

  assign irq = |(status & ~mask);
endmodule

// File: rtl/msi_doorbell_ctrl.sv
`timescale 1ns/1ps
module msi_doorbell_ctrl import msi_db_pkg::*; #(
  parameter int          DATA_W      = 32,
  parameter int          ADDR_W      = 2 * DATA_W,
  parameter logic [15:0] HW_REV      = REV_WIDE_LAYOUT,
  parameter int          LEGACY_VECS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [DATA_W-1:0] in_data,
  output logic              fwd_valid,
  output logic [ADDR_W-1:0] fwd_addr,
  output logic [DATA_W-1:0] fwd_data,
  input  logic              reg_we,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq
);
  localparam int  STAT_W   = DATA_W;
  localparam int  FW       = DATA_W / 2;
  localparam bit  WIDE     = (HW_REV >= REV_WIDE_LAYOUT);
  localparam int  NUM_VEC  = WIDE ? STAT_W : LEGACY_VECS;
  localparam int  VEC_BASE = WIDE ? 0 : (STAT_W - LEGACY_VECS);

  logic [DATA_W-1:0] tgt_lo_q, tgt_hi_q, dcfg_q;
  logic [ADDR_W-1:0] tgt_addr;
  logic              msi_en;
  logic              recog;
  logic [STAT_W-1:0] hit_vec;
  logic [STAT_W-1:0] status_q, mask_q;
  logic [STAT_W-1:0] vec_valid;
  logic              set_wr, clr_wr, mset_wr, mclr_wr;

  assign tgt_addr = {tgt_hi_q, tgt_lo_q[DATA_W-1:2], 2'b00};
  assign msi_en   = tgt_lo_q[0];

  always_comb begin
    vec_valid = '0;
    for (int i = 0; i < NUM_VEC; i++) vec_valid[VEC_BASE+i] = 1'b1;
    set_wr  = reg_we && (reg_addr == RA_SET);
    clr_wr  = reg_we && (reg_addr == RA_CLEAR);
    mset_wr = reg_we && (reg_addr == RA_MASK_SET);
    mclr_wr = reg_we && (reg_addr == RA_MASK_CLR);
  end

  msi_db_cfg #(.DATA_W(DATA_W)) u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .tgt_lo_q  (tgt_lo_q),
    .tgt_hi_q  (tgt_hi_q),
    .dcfg_q    (dcfg_q)
  );

  msi_db_match #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .STAT_W(STAT_W),
    .NUM_VEC(NUM_VEC), .VEC_BASE(VEC_BASE)
  ) u_match (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_addr    (in_addr),
    .in_data    (in_data),
    .msi_en     (msi_en),
    .tgt_addr   (tgt_addr),
    .match_mask (dcfg_q[DATA_W-1:FW]),
    .match_val  (dcfg_q[FW-1:0]),
    .recog      (recog),
    .hit_vec    (hit_vec),
    .fwd_valid  (fwd_valid),
    .fwd_addr   (fwd_addr),
    .fwd_data   (fwd_data)
  );

  msi_db_pending #(
    .STAT_W(STAT_W), .NUM_VEC(NUM_VEC), .VEC_BASE(VEC_BASE)
  ) u_pend (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_wr  (set_wr),
    .clr_wr  (clr_wr),
    .mset_wr (mset_wr),
    .mclr_wr (mclr_wr),
    .wdata   (reg_wdata),
    .msi_set (hit_vec),
    .status  (status_q),
    .mask    (mask_q),
    .irq     (irq)
  );

  always_comb begin
    reg_rdata = '0;
    case (reg_idx_e'(reg_addr))
      RA_PEND:   reg_rdata = status_q;
      RA_MASK:   reg_rdata = mask_q;
      RA_TGT_LO: reg_rdata = tgt_lo_q;
      RA_TGT_HI: reg_rdata = tgt_hi_q;
      RA_DCFG:   reg_rdata = dcfg_q;
      RA_REV:    reg_rdata = {{(DATA_W-16){1'b0}}, HW_REV};
      default:   reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/msi_db_chk.sv
`timescale 1ns/1ps
module msi_db_chk import msi_db_pkg::*; #(
  parameter int STAT_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              recog,
  input logic              msi_en,
  input logic [STAT_W-1:0] hit_vec,
  input logic [STAT_W-1:0] status_q,
  input logic [STAT_W-1:0] mask_q,
  input logic [STAT_W-1:0] vec_valid,
  input logic              fwd_valid,
  input logic              irq,
  input logic              reg_we,
  input logic [REG_AW-1:0] reg_addr,
  input logic [STAT_W-1:0] reg_wdata
);
  // R2
  disabled_no_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !msi_en |-> (hit_vec == '0));

  // R3
  hit_sets_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_vec != '0) |=> ((status_q & $past(hit_vec)) == $past(hit_vec)));

  // R4
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((status_q & ~vec_valid) == '0) && ((mask_q & ~vec_valid) == '0));

  // R6
  clear_acts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && (reg_addr == RA_CLEAR) && (hit_vec == '0))
      |=> ((status_q & $past(reg_wdata)) == '0));

  // R7
  clear_collision_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && (reg_addr == RA_CLEAR) && ((hit_vec & reg_wdata) != '0))
      |=> ((status_q & $past(hit_vec & reg_wdata)) != '0));

  // R8
  all_masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == vec_valid) |-> !irq);

  // R9
  miss_forwarded_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !recog) |=> fwd_valid);

  // R9
  hit_not_forwarded_chk: assert property (@(posedge clk) disable iff (!rst_n)
    recog |=> !fwd_valid);
endmodule

bind msi_doorbell_ctrl msi_db_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .recog     (recog),
  .msi_en    (msi_en),
  .hit_vec   (hit_vec),
  .status_q  (status_q),
  .mask_q    (mask_q),
  .vec_valid (vec_valid),
  .fwd_valid (fwd_valid),
  .irq       (irq),
  .reg_we    (reg_we),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata)
);

// File: tb/msi_doorbell_ctrl_test.sv
`timescale 1ns/1ps
module msi_doorbell_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [63:0] in_addr = '0;
  logic [31:0] in_data = '0;
  logic        reg_we = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;

  logic        fv0, fv1, irq0, irq1;
  logic [63:0] fa0, fa1;
  logic [31:0] fd0, fd1, rd0, rd1;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  bit model_ok = 1'b0;

  always #2.5 clk = ~clk;

  msi_doorbell_ctrl uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_addr(in_addr), .in_data(in_data),
    .fwd_valid(fv0), .fwd_addr(fa0), .fwd_data(fd0),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(rd0), .irq(irq0)
  );

  msi_doorbell_ctrl #(.HW_REV(16'h0210)) uut_legacy (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_addr(in_addr), .in_data(in_data),
    .fwd_valid(fv1), .fwd_addr(fa1), .fwd_data(fd1),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(rd1), .irq(irq1)
  );

  // behavioural model state, index 0 = current layout, 1 = legacy layout
  int unsigned     m_st[2], m_mk[2], m_fd[2];
  bit              m_fv[2];
  longint unsigned m_fa[2];
  int unsigned     m_tlo, m_thi, m_dcfg;

  function automatic int unsigned valid_of(int k);
    return (k == 0) ? 32'hFFFF_FFFF : 32'hFF00_0000;
  endfunction

  function automatic int unsigned exp_rd(int k, int a);
    case (a)
      0: return m_st[k];
      3: return m_mk[k];
      6: return m_tlo;
      7: return m_thi;
      8: return m_dcfg;
      9: return (k == 0) ? 32'h0000_0303 : 32'h0000_0210;
      default: return 0;
    endcase
  endfunction

  function automatic string rd_tag(int a);
    case (a)
      0, 1, 2, 3, 4, 5: return "R6";
      9: return "R10";
      default: return "R5";
    endcase
  endfunction

  task automatic chk(string tag, longint unsigned act, longint unsigned exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < 2; k++) begin
        m_st[k] = 0; m_mk[k] = valid_of(k); m_fv[k] = 0; m_fa[k] = 0; m_fd[k] = 0;
      end
      m_tlo = 0; m_thi = 0; m_dcfg = 0;
    end else begin
      longint unsigned tgt;
      bit              rec;
      int unsigned     vec, setb, clrw, setw, msw, mcw;
      tgt  = {m_thi, m_tlo};
      rec  = in_valid && m_tlo[0] && ((in_addr >> 2) == (tgt >> 2)) &&
             ((((in_data[15:0] ^ m_dcfg[15:0]) & m_dcfg[31:16])) == 0);
      vec  = in_data[15:0] & ~m_dcfg[31:16];
      setw = (reg_we && reg_addr == 1) ? reg_wdata : 0;
      clrw = (reg_we && reg_addr == 2) ? reg_wdata : 0;
      msw  = (reg_we && reg_addr == 4) ? reg_wdata : 0;
      mcw  = (reg_we && reg_addr == 5) ? reg_wdata : 0;
      for (int k = 0; k < 2; k++) begin
        int base, num;
        base = (k == 0) ? 0 : 24;
        num  = (k == 0) ? 32 : 8;
        setb = (rec && vec < num) ? (32'd1 << (base + vec)) : 0;
        m_st[k] = ((m_st[k] & ~clrw) | setw | setb) & valid_of(k);
        m_mk[k] = ((m_mk[k] & ~mcw) | msw) & valid_of(k);
        m_fv[k] = in_valid && !rec;
        if (m_fv[k]) begin m_fa[k] = in_addr; m_fd[k] = in_data; end
      end
      if (reg_we && reg_addr == 6) m_tlo = reg_wdata & 32'hFFFF_FFFD;
      if (reg_we && reg_addr == 7) m_thi = reg_wdata;
      if (reg_we && reg_addr == 8) m_dcfg = reg_wdata;
    end
    model_ok = 1'b1;
    #1;
    if (model_ok && !done) begin
      chk("R8 irq", irq0, (m_st[0] & ~m_mk[0]) != 0);
      chk("R8 irq legacy", irq1, (m_st[1] & ~m_mk[1]) != 0);
      chk("R9 fwd_valid", fv0, m_fv[0]);
      chk("R9 fwd_valid legacy", fv1, m_fv[1]);
      if (m_fv[0]) begin chk("R9 fwd_addr", fa0, m_fa[0]); chk("R9 fwd_data", fd0, m_fd[0]); end
      if (m_fv[1]) begin chk("R9 fwd_addr legacy", fa1, m_fa[1]); chk("R9 fwd_data legacy", fd1, m_fd[1]); end
      chk(rd_tag(reg_addr), rd0, exp_rd(0, reg_addr));
      chk(rd_tag(reg_addr), rd1, exp_rd(1, reg_addr));
    end
  end

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0; reg_we = 1'b0;
  endtask

  task automatic regwr(int a, int unsigned d);
    @(negedge clk);
    in_valid = 1'b0; reg_we = 1'b1; reg_addr = 4'(a); reg_wdata = d;
  endtask

  task automatic inwr(longint unsigned a, int unsigned d);
    @(negedge clk);
    reg_we = 1'b0; in_valid = 1'b1; in_addr = a; in_data = d;
  endtask

  task automatic rd_both(int a, int unsigned e0, int unsigned e1, string tag);
    @(negedge clk);
    in_valid = 1'b0; reg_we = 1'b0; reg_addr = 4'(a);
    @(posedge clk); #1;
    chk(tag, rd0, e0);
    chk({tag, " legacy"}, rd1, e1);
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog R1 actual=hung expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    reg_addr = 4'd3;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 mask reset", rd0, 32'hFFFF_FFFF);
    chk("R1 mask reset legacy", rd1, 32'hFF00_0000);
    chk("R1 irq reset", irq0, 0);
    @(negedge clk); rst_n = 1'b1;
    rd_both(0, 0, 0, "R1 pending reset");
    rd_both(6, 0, 0, "R1 address reset");
    // R5 / R10: sweep every index
    for (int a = 0; a < 16; a++) idle_read(a);
    rd_both(9, 32'h0303, 32'h0210, "R10 revision");
    // R5: writes to read-only indices ignored
    regwr(9, 32'hFFFF_FFFF);
    regwr(0, 32'hFFFF_FFFF);
    regwr(3, 0);
    rd_both(3, 32'hFFFF_FFFF, 32'hFF00_0000, "R5 mask write ignored");
    rd_both(9, 32'h0303, 32'h0210, "R5 revision write ignored");
    // configure, still disabled
    regwr(7, 0);
    regwr(6, 32'hFFFF_FFFE);
    regwr(8, 32'hFFE0_6540);
    rd_both(6, 32'hFFFF_FFFC, 32'hFFFF_FFFC, "R5 address low bit1 reads 0");
    inwr(64'hFFFF_FFFC, 32'h6541);
    rd_both(0, 0, 0, "R2 disabled write ignored");
    // enable and unmask
    regwr(6, 32'hFFFF_FFFD);
    regwr(5, 32'hFFFF_FFFF);
    rd_both(3, 0, 0, "R6 mask clear");
    inwr(64'hFFFF_FFFC, 32'h6540);
    inwr(64'hFFFF_FFFC, 32'h6545);
    inwr(64'hFFFF_FFFC, 32'h6547);
    inwr(64'hFFFF_FFFC, 32'h6549);
    inwr(64'hFFFF_FFFC, 32'h655F);
    inwr(64'hFFFF_FFFF, 32'h6543);
    inwr(64'h1_FFFF_FFFC, 32'h6540);
    inwr(64'hFFFF_FFFC, 32'h6440);
    rd_both(0, 32'h8000_02A9, 32'hA900_0000, "R3 vector decode");
    chk("R4 legacy irq", irq1, 1);
    // R7: clear collides with a new write of vector 5
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 4'd2; reg_wdata = 32'h2100_0021;
    in_valid = 1'b1; in_addr = 64'hFFFF_FFFC; in_data = 32'h6545;
    rd_both(0, 32'h8000_02A8, 32'hA800_0000, "R7 clear collision");
    // R6: zero clear has no effect
    regwr(2, 0);
    rd_both(0, 32'h8000_02A8, 32'hA800_0000, "R6 zero clear");
    // R8: mask everything
    regwr(4, 32'hFFFF_FFFF);
    idle();
    chk("R8 all masked", irq0, 0);
    regwr(2, 32'hFFFF_FFFF);
    regwr(1, 32'h0200_0100);
    rd_both(0, 32'h0200_0100, 32'h0200_0000, "R4 set lane range");
    regwr(5, 32'h0000_0100);
    idle();
    chk("R8 irq unmasked", irq0, 1);
    chk("R8 irq still masked legacy", irq1, 0);
    // narrower mask and high doorbell address
    regwr(8, 32'hFFF8_6540);
    regwr(7, 32'h0000_000F);
    inwr(64'hF_FFFF_FFFC, 32'h654F);
    inwr(64'hF_FFFF_FFFC, 32'h6546);
    inwr(64'hFFFF_FFFC, 32'h6546);
    rd_both(0, 32'h0200_0140, 32'h4200_0000, "R2 R3 high address match");
    repeat (3) idle();
    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  task automatic idle_read(int a);
    @(negedge clk);
    in_valid = 1'b0; reg_we = 1'b0; reg_addr = 4'(a);
  endtask
endmodule